// File: doc/BRIEF.md
# Variable-Slot In-Order Retire Queue

This block keeps in-flight instructions in program order in a ring of slots. Each instruction may take more than one slot. A dispatch request carries an instruction tag and a micro-op count. The count is turned into a slot count: a count of zero takes one slot, and a count larger than the ring takes the whole ring. If enough slots are free, the block reserves a contiguous run of slots starting at the tail. It hands back the starting slot index as the instruction's token.

When an instruction finishes, execution reports its token on a separate port, and the entry is marked done. Every cycle the block looks at entries from the head, in order. It retires each done entry until it meets an entry that is not done, the ring runs empty, or the per-cycle limit is reached. Each retirement shows its tag on one output lane and gives its slots back. The free-slot count is exported so that dispatch logic can plan ahead.

The limit input caps retirements per cycle. A limit of zero allows as many as the hardware has lanes (MAX_RETIRE).

Top module: `retire_queue`

## Requirements
- R1: After a synchronous active-low reset, free_slots equals DEPTH, disp_token is 0, and no ret_valid lane is set.
- R2: A reservation takes max(1, min(disp_uops, DEPTH)) slots, and free_slots drops by that amount on the next cycle.
- R3: disp_token shows the tail index before the reservation. The tail advances by the slot count modulo DEPTH, so the next token wraps past DEPTH-1 back to 0.
- R4: disp_ready is high only when free_slots is at least the normalized slot count. A request made while disp_ready is low changes neither free_slots nor disp_token.
- R5: An entry retires only after its token was given on exec_token with exec_valid. Retirement stops at the first entry from the head that is not done, and nothing retires while the ring is empty.
- R6: At most retire_limit entries retire per cycle when retire_limit is nonzero. A retire_limit of 0 allows up to MAX_RETIRE per cycle, all in one cycle.
- R7: Retired tags appear on the ret_tag lanes in dispatch order. Lane i occupies bits [i*TAG_W +: TAG_W], and each retirement gives the entry's slot count back to free_slots.
- R8: When a reservation and retirements fall in the same cycle, free_slots becomes old + freed - reserved, and never exceeds DEPTH.
- R9: The valid retire lanes form a prefix: lane i is valid only if lane i-1 is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_tag | input | TAG_W | Instruction tag to record |
| disp_uops | input | UOP_W | Micro-op count of the instruction |
| disp_ready | output | 1 | Enough free slots for the current request |
| disp_token | output | PTR_W | Token (start slot) the request gets |
| exec_valid | input | 1 | Executed notification |
| exec_token | input | PTR_W | Token of the executed instruction |
| retire_limit | input | LIM_W | Per-cycle retire cap, 0 means MAX_RETIRE |
| ret_valid | output | MAX_RETIRE | Retire lane valid bits |
| ret_tag | output | MAX_RETIRE*TAG_W | Retired tags, lane i at bits i*TAG_W |
| free_slots | output | CNT_W | Number of unreserved slots |

## Verification
A wrong head pointer or a wrong slot count shows up at the ports one cycle after the faulty update. Tags then come out of order or from stale slots, and free_slots stops returning to DEPTH once everything has drained. A lost or misplaced done flag shows up in the cycle after the notification, either as a stalled ring or as a tag that retires early. A wrong tail shows up right away as an unexpected disp_token on the next dispatch. The bench gives the instructions out of order, holds a refused request, wraps the ring, fills it with one clamped entry, and overlaps a dispatch with a retirement so that each of these faults is visible.

// File: rtl/rq_slot_norm.sv
// rq_slot_norm: turns a micro-op count into the number of ring slots it uses.
// Assumes DEPTH >= 1; a zero count still needs one slot, counts above DEPTH use DEPTH.
module rq_slot_norm #(
    parameter int DEPTH = 16,
    parameter int UOP_W = 5,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [UOP_W-1:0] uops,
    output logic [CNT_W-1:0] slots
);
    // Clamp the count into the range 1..DEPTH.
    always_comb begin
        if (uops == '0)
            slots = CNT_W'(1);
        else if (int'(uops) > DEPTH)
            slots = CNT_W'(DEPTH);
        else
            slots = CNT_W'(int'(uops));
    end
endmodule

// File: rtl/rq_entry_store.sv
// rq_entry_store: per-slot tag, slot count and done flag. Only the start slot of an
// entry has meaning. Assumes execution reports only live entries that are not yet done.
module rq_entry_store #(
    parameter int DEPTH = 16,
    parameter int TAG_W = 8,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [CNT_W-1:0] wr_slots,
    input  logic             ex_en,
    input  logic [PTR_W-1:0] ex_ptr,
    output logic [TAG_W-1:0] tag_q   [DEPTH],
    output logic [CNT_W-1:0] slots_q [DEPTH],
    output logic             done_q  [DEPTH]
);
    // Write a new entry at its start slot, or set its done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tag_q[i]   <= '0;
                slots_q[i] <= CNT_W'(1);
                done_q[i]  <= 1'b0;
            end
        end else begin
            if (ex_en)
                done_q[ex_ptr] <= 1'b1;
            if (wr_en) begin
                tag_q[wr_ptr]   <= wr_tag;
                slots_q[wr_ptr] <= wr_slots;
                done_q[wr_ptr]  <= 1'b0;
            end
        end
    end

    // R5: a notification must name an entry that is not yet done
    assert_exec_fresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ex_en |-> !done_q[ex_ptr]);
endmodule

// File: rtl/rq_retire_walk.sv
// rq_retire_walk: finds the entries that retire this cycle by walking from the head.
// It stops at an entry that is not done, when the live slots run out, or at the limit.
// Assumes used <= DEPTH and that head points at the start of a live entry when used > 0.
module rq_retire_walk #(
    parameter int DEPTH      = 16,
    parameter int TAG_W      = 8,
    parameter int MAX_RETIRE = 4,
    parameter int PTR_W      = $clog2(DEPTH),
    parameter int CNT_W      = $clog2(DEPTH + 1),
    parameter int LIM_W      = $clog2(MAX_RETIRE + 1)
) (
    input  logic [PTR_W-1:0]  head,
    input  logic [CNT_W-1:0]  used,
    input  logic [LIM_W-1:0]  limit,
    input  logic [TAG_W-1:0]  tag_q   [DEPTH],
    input  logic [CNT_W-1:0]  slots_q [DEPTH],
    input  logic              done_q  [DEPTH],
    output logic [MAX_RETIRE-1:0]       lane_valid,
    output logic [MAX_RETIRE*TAG_W-1:0] lane_tag,
    output logic [CNT_W-1:0]  freed
);
    int p;
    int left;
    int sum;
    int n;
    int cap;
    logic go;

    // Walk the lanes in order; each lane takes the next entry if it may retire.
    always_comb begin
        p    = int'(head);
        left = int'(used);
        sum  = 0;
        n    = 0;
        go   = 1'b1;
        cap  = (limit == '0) ? MAX_RETIRE : int'(limit);
        lane_valid = '0;
        lane_tag   = '0;
        for (int i = 0; i < MAX_RETIRE; i++) begin
            lane_tag[i*TAG_W +: TAG_W] = tag_q[PTR_W'(p)];
            if (go && left > 0 && i < cap && done_q[PTR_W'(p)]) begin
                lane_valid[i] = 1'b1;
                n    = int'(slots_q[PTR_W'(p)]);
                sum  = sum + n;
                left = left - n;
                p    = p + n;
                if (p >= DEPTH)
                    p = p - DEPTH;
            end else begin
                go = 1'b0;
            end
        end
        freed = CNT_W'(sum);
    end
endmodule

// File: rtl/retire_queue.sv
// retire_queue: ring of DEPTH slots that holds instructions in program order. Each
// instruction takes a variable number of slots and retires in order, up to a limit.
// Assumes exec_token names a live entry that is not yet done. Dispatch waits for
// disp_ready; a request made while it is low is simply ignored.
module retire_queue #(
    parameter int DEPTH      = 16,
    parameter int TAG_W      = 8,
    parameter int UOP_W      = 5,
    parameter int MAX_RETIRE = 4,
    parameter int PTR_W      = $clog2(DEPTH),
    parameter int CNT_W      = $clog2(DEPTH + 1),
    parameter int LIM_W      = $clog2(MAX_RETIRE + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        disp_valid,
    input  logic [TAG_W-1:0]            disp_tag,
    input  logic [UOP_W-1:0]            disp_uops,
    output logic                        disp_ready,
    output logic [PTR_W-1:0]            disp_token,
    input  logic                        exec_valid,
    input  logic [PTR_W-1:0]            exec_token,
    input  logic [LIM_W-1:0]            retire_limit,
    output logic [MAX_RETIRE-1:0]       ret_valid,
    output logic [MAX_RETIRE*TAG_W-1:0] ret_tag,
    output logic [CNT_W-1:0]            free_slots
);
    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] avail_q;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] freed;
    logic             take;
    logic [PTR_W-1:0] tail_n, head_n;
    logic [TAG_W-1:0] tag_q   [DEPTH];
    logic [CNT_W-1:0] slots_q [DEPTH];
    logic             done_q  [DEPTH];

    rq_slot_norm #(.DEPTH(DEPTH), .UOP_W(UOP_W), .CNT_W(CNT_W)) u_norm (
        .uops (disp_uops),
        .slots(need)
    );

    rq_entry_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (take),
        .wr_ptr  (tail_q),
        .wr_tag  (disp_tag),
        .wr_slots(need),
        .ex_en   (exec_valid),
        .ex_ptr  (exec_token),
        .tag_q   (tag_q),
        .slots_q (slots_q),
        .done_q  (done_q)
    );

    rq_retire_walk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .MAX_RETIRE(MAX_RETIRE),
                     .PTR_W(PTR_W), .CNT_W(CNT_W), .LIM_W(LIM_W)) u_walk (
        .head      (head_q),
        .used      (CNT_W'(DEPTH) - avail_q),
        .limit     (retire_limit),
        .tag_q     (tag_q),
        .slots_q   (slots_q),
        .done_q    (done_q),
        .lane_valid(ret_valid),
        .lane_tag  (ret_tag),
        .freed     (freed)
    );

    // Check capacity against the count held at the start of the cycle.
    always_comb begin
        disp_ready = (avail_q >= need);
        take       = disp_valid && disp_ready;
        disp_token = tail_q;
        free_slots = avail_q;
    end

    // Move both pointers forward with wrap-around modulo DEPTH.
    always_comb begin
        if (int'(tail_q) + int'(need) >= DEPTH)
            tail_n = PTR_W'(int'(tail_q) + int'(need) - DEPTH);
        else
            tail_n = PTR_W'(int'(tail_q) + int'(need));
        if (int'(head_q) + int'(freed) >= DEPTH)
            head_n = PTR_W'(int'(head_q) + int'(freed) - DEPTH);
        else
            head_n = PTR_W'(int'(head_q) + int'(freed));
    end

    // Update the pointers and the free count: old + freed - reserved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            avail_q <= CNT_W'(DEPTH);
        end else begin
            head_q  <= head_n;
            if (take)
                tail_q <= tail_n;
            avail_q <= avail_q + freed - (take ? need : CNT_W'(0));
        end
    end

    // R8: the free count never goes past the ring size
    assert_free_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        free_slots <= CNT_W'(DEPTH));

    // R4: a refused request with no retirement leaves the count and the token alone
    assert_hold_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready && ret_valid == '0) |=> ($stable(free_slots) && $stable(disp_token)));

    // R5: an empty ring retires nothing
    assert_empty_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (free_slots == CNT_W'(DEPTH)) |-> (ret_valid == '0));

    // R6: a nonzero limit caps the lanes used in a cycle
    assert_limit_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_limit != '0) |-> ($countones(ret_valid) <= int'(retire_limit)));

    // R9: valid lanes form a prefix
    generate
        for (genvar g = 1; g < MAX_RETIRE; g++) begin : g_prefix
            assert_lane_prefix_R9: assert property (@(posedge clk) disable iff (!rst_n)
                ret_valid[g] |-> ret_valid[g-1]);
        end
    endgenerate
endmodule

// File: tb/test_retire_queue.sv
`timescale 1ns/1ps
module test_retire_queue;
    localparam int DEPTH = 16, TAG_W = 8, UOP_W = 5, MAXR = 4;
    localparam int PTR_W = $clog2(DEPTH), CNT_W = $clog2(DEPTH + 1), LIM_W = $clog2(MAXR + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic disp_valid = 1'b0, exec_valid = 1'b0;
    logic [TAG_W-1:0] disp_tag = '0;
    logic [UOP_W-1:0] disp_uops = '0;
    logic [PTR_W-1:0] exec_token = '0;
    logic [LIM_W-1:0] retire_limit = '0;
    logic disp_ready;
    logic [PTR_W-1:0] disp_token;
    logic [MAXR-1:0] ret_valid;
    logic [MAXR*TAG_W-1:0] ret_tag;
    logic [CNT_W-1:0] free_slots;

    int checks = 0, fails = 0, peak = 0;
    logic [TAG_W-1:0] expq[$];
    bit over = 1'b0;

    always #4 clk = ~clk;

    retire_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .UOP_W(UOP_W), .MAX_RETIRE(MAXR)) i_retire_queue (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_tag(disp_tag),
        .disp_uops(disp_uops), .disp_ready(disp_ready), .disp_token(disp_token),
        .exec_valid(exec_valid), .exec_token(exec_token), .retire_limit(retire_limit),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .free_slots(free_slots));

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Monitor: pops expected tags in order as lanes retire them.
    always @(negedge clk) begin
        if (rst_n && !over) begin
            int cnt;
            cnt = 0;
            for (int i = 0; i < MAXR; i++) begin
                if (ret_valid[i]) begin
                    cnt++;
                    if (expq.size() == 0) begin
                        chk(1'b0, "R5 retire with nothing pending", int'(ret_tag[i*TAG_W +: TAG_W]), -1);
                    end else begin
                        logic [TAG_W-1:0] e;
                        e = expq.pop_front();
                        chk(ret_tag[i*TAG_W +: TAG_W] == e, "R7 retired tag order",
                            int'(ret_tag[i*TAG_W +: TAG_W]), int'(e));
                    end
                end
            end
            if (retire_limit != '0)
                chk(cnt <= int'(retire_limit), "R6 lanes over limit", cnt, int'(retire_limit));
            if (cnt > peak) peak = cnt;
        end
    end

    // Driver: one dispatch cycle; pushes the tag when the request is taken.
    task automatic dispatch(input int tag, input int uops, input int exp_tok, input bit exp_ok);
        disp_valid = 1'b1;
        disp_tag   = TAG_W'(tag);
        disp_uops  = UOP_W'(uops);
        @(negedge clk);
        chk(int'(disp_token) == exp_tok, "R3 token", int'(disp_token), exp_tok);
        chk(disp_ready == exp_ok, "R4 ready", int'(disp_ready), int'(exp_ok));
        if (disp_ready) expq.push_back(TAG_W'(tag));
        @(posedge clk); #1;
        disp_valid = 1'b0;
    endtask

    task automatic exec(input int tok);
        exec_valid = 1'b1;
        exec_token = PTR_W'(tok);
        @(posedge clk); #1;
        exec_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_free(input int exp, input string what);
        @(negedge clk);
        chk(int'(free_slots) == exp, what, int'(free_slots), exp);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk(int'(free_slots) == DEPTH, "R1 free after reset", int'(free_slots), DEPTH);
        chk(disp_token == '0, "R1 token after reset", int'(disp_token), 0);
        chk(ret_valid == '0, "R1 no retire after reset", int'(ret_valid), 0);
        @(posedge clk); #1;

        // R2: normal count and zero count
        dispatch(8'h11, 3, 0, 1'b1);
        check_free(13, "R2 three uops take three slots");
        dispatch(8'h22, 0, 3, 1'b1);
        check_free(12, "R2 zero uops take one slot");
        // R4: clamped request (16 slots) refused, state held
        dispatch(8'h33, 31, 4, 1'b0);
        check_free(12, "R4 refused request leaves free count");
        @(negedge clk);
        chk(int'(disp_token) == 4, "R4 refused request leaves token", int'(disp_token), 4);
        @(posedge clk); #1;

        // R5: younger entry done first must not retire
        exec(3);
        @(negedge clk);
        chk(ret_valid == '0, "R5 stall behind pending head", int'(ret_valid), 0);
        @(posedge clk); #1;
        exec(0);
        idle(3);
        check_free(DEPTH, "R7 slots returned after retire");

        // R3: wrap the tail
        dispatch(8'h41, 5, 4, 1'b1);
        dispatch(8'h42, 5, 9, 1'b1);
        dispatch(8'h43, 5, 14, 1'b1);
        dispatch(8'h44, 1, 3, 1'b1);
        check_free(0, "R2 ring full");
        dispatch(8'h45, 1, 4, 1'b0);

        // R8: dispatch in the cycle a retirement happens
        exec(4);
        idle(2);
        check_free(5, "R7 five slots back");
        exec(9);
        dispatch(8'h46, 2, 4, 1'b1);
        check_free(8, "R8 old + freed - reserved");

        // R6: limit of one
        retire_limit = LIM_W'(1);
        peak = 0;
        exec(14);
        exec(3);
        exec(4);
        idle(5);
        check_free(DEPTH, "R6 drained under limit one");
        chk(peak == 1, "R6 peak lanes with limit one", peak, 1);

        // R6: limit zero retires MAX_RETIRE in one cycle
        retire_limit = '0;
        peak = 0;
        for (int k = 0; k < 5; k++) dispatch(8'h50 + k, 1, 6 + k, 1'b1);
        for (int k = 4; k >= 0; k--) exec(6 + k);
        idle(4);
        chk(peak == MAXR, "R6 peak lanes with limit zero", peak, MAXR);
        check_free(DEPTH, "R7 drained after burst");

        // R2: oversize count clamps to the whole ring
        dispatch(8'h60, 20, 11, 1'b1);
        check_free(0, "R2 clamp to DEPTH");
        dispatch(8'h61, 0, 11, 1'b0);
        exec(11);
        idle(3);
        check_free(DEPTH, "R7 clamped entry returns DEPTH");
        chk(expq.size() == 0, "R7 all tags retired", expq.size(), 0);

        over = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!over) begin
            over = 1'b1;
            checks++;
            fails++;
            $display("FAIL R5 watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule